// File: doc/BRIEF.md
# Resource Power Sequencing Controller

This block switches a small set of power resources on and off in dependency order inside a power-management unit. Software presents a target on/off pattern. Each resource has three settings: a mask of the other resources it needs, a settle count for power-up and a settle count for power-down. The controller moves toward the target one resource at a time. For each step it raises or drops that resource's enable and waits the programmed settle count. Only then does it mark the resource ready, or remove its enable.

A clock-available flag tells the clock logic when every requested resource is up. The block also holds an extended reset low for a programmable number of cycles after the raw reset is released. Nothing is sequenced until that extended reset ends. A sticky flag reports a request pattern that can never be met: a resource wanted on while something it needs is wanted off.

Top module: `rps_ctrl`

## Requirements
- R1: After the raw reset `rst_n` is released with `por_len` = L, `rst_ext_n` stays low for exactly L+1 clock edges, rises on edge L+1, and then stays high until the next raw reset.
- R2: No resource enable is set while `rst_ext_n` is low. The first transition is selected on the edge after `rst_ext_n` rises.
- R3: Bit j of `dep_mask[i*NUM_RES +: NUM_RES]` means resource i needs resource j; bit i of its own field is ignored. Resource i starts power-up only when every resource it needs is ready. A resource whose needs are never ready is never enabled.
- R4: A resource starts power-down only when no enabled resource needs it.
- R5: Only one resource is in transition at a time. When the controller is idle, the lowest-index resource eligible for power-up is chosen first. If none is eligible, the highest-index resource eligible for power-down is chosen.
- R6: Power-up of resource i with `up_time[i*TIME_W +: TIME_W]` = T runs as follows:
  - its enable rises on the selection edge;
  - its ready flag rises T+1 edges later;
  - the next selection happens one edge after that.
- R7: Power-down of resource i with `dn_time[i*TIME_W +: TIME_W]` = D runs as follows:
  - its ready flag falls on the selection edge;
  - its enable falls D+1 edges later;
  - the next selection happens one edge after that.
- R8: A change of `req_on` during a transition is not looked at until the current resource has finished settling.
- R9: `clk_avail` is high exactly when `rst_ext_n` is high, `req_on` is nonzero and every requested resource is ready.
- R10: `dep_err` rises one edge after a resource is requested on while a resource it needs is requested off. It then stays high until the raw reset.
- R11: Clearing the request bit of a single resource turns off only that resource. All other ready resources stay ready.
- R12: While `rst_n` is low, all of the following outputs are 0: the enables, the ready flags, `clk_avail`, `rst_ext_n` and `dep_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Raw asynchronous reset, active low |
| por_len | input | POR_W | Extra cycles the extended reset is held |
| req_on | input | NUM_RES | Target state, one bit per resource |
| dep_mask | input | NUM_RES*NUM_RES | Per-resource mask of needed resources |
| up_time | input | NUM_RES*TIME_W | Per-resource power-up settle count |
| dn_time | input | NUM_RES*TIME_W | Per-resource power-down settle count |
| res_en | output | NUM_RES | Resource enables |
| res_rdy | output | NUM_RES | Resource ready flags |
| clk_avail | output | 1 | All requested resources are ready |
| rst_ext_n | output | 1 | Extended reset, active low |
| dep_err | output | 1 | Sticky unmet-dependency flag |

## Verification
For each request, the bench first works out the order of transitions using the R3, R4 and R5 rules. From the settle counts it then derives the edge on which each transition starts. A power-up is due T+1 edges after its start and the next start comes one edge after that; the power-down and reset timings are counted the same way. The bench counts edges from the falling edge on which it changes a request or releases reset, and samples each flag on the falling edge right after the edge it is due. It also samples one edge before the due edge, so a flag that moves early or late is caught. Since `clk_avail` is combinational, it is checked at the same falling edge as the final ready flag.

// File: rtl/rps_pkg.sv
package rps_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_UP   = 2'd1,
      SQ_DOWN = 2'd2
   } sq_state_t;
endpackage

// File: rtl/rps_por_stretch.sv
module rps_por_stretch #(
   parameter int POR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POR_W-1:0] len,
   output logic             done
);
   logic [POR_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q == len) done_q <= 1'b1;
         else              cnt_q  <= cnt_q + POR_W'(1);
      end
   end

   assign done = done_q;

   AST_POR_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> done_q); // R1
endmodule

// File: rtl/rps_pick.sv
module rps_pick #(
   parameter int NUM_RES = 8,
   parameter int IDX_W   = 3
) (
   input  logic [NUM_RES-1:0]         req,
   input  logic [NUM_RES-1:0]         en,
   input  logic [NUM_RES-1:0]         rdy,
   input  logic [NUM_RES*NUM_RES-1:0] dep_flat,
   output logic                       up_vld,
   output logic [IDX_W-1:0]           up_idx,
   output logic                       dn_vld,
   output logic [IDX_W-1:0]           dn_idx
);
   logic [NUM_RES-1:0] up_ok;
   logic [NUM_RES-1:0] dn_ok;

   for (genvar i = 0; i < NUM_RES; i++) begin : g_res
      logic [NUM_RES-1:0] need;
      logic [NUM_RES-1:0] users;
      assign need = dep_flat[i*NUM_RES +: NUM_RES] & ~(NUM_RES'(1) << i);
      for (genvar j = 0; j < NUM_RES; j++) begin : g_user
         if (j == i) begin : g_self
            assign users[j] = 1'b0;
         end else begin : g_other
            assign users[j] = en[j] & dep_flat[j*NUM_RES + i];
         end
      end
      assign up_ok[i] = req[i] & ~en[i] & ((need & ~rdy) == '0);
      assign dn_ok[i] = ~req[i] & en[i] & (users == '0);
   end

   always_comb begin
      up_vld = 1'b0;
      up_idx = '0;
      for (int i = NUM_RES-1; i >= 0; i--) begin
         if (up_ok[i]) begin
            up_vld = 1'b1;
            up_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      dn_vld = 1'b0;
      dn_idx = '0;
      for (int i = 0; i < NUM_RES; i++) begin
         if (dn_ok[i]) begin
            dn_vld = 1'b1;
            dn_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/rps_err_mon.sv
module rps_err_mon #(
   parameter int NUM_RES = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_RES-1:0]         req,
   input  logic [NUM_RES*NUM_RES-1:0] dep_flat,
   output logic                       err
);
   logic [NUM_RES-1:0] bad;
   logic               err_q;

   for (genvar i = 0; i < NUM_RES; i++) begin : g_chk
      logic [NUM_RES-1:0] need;
      assign need   = dep_flat[i*NUM_RES +: NUM_RES] & ~(NUM_RES'(1) << i);
      assign bad[i] = req[i] & ((need & ~req) != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else if (|bad) err_q <= 1'b1;
   end

   assign err = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_q |=> err_q); // R10
endmodule

// File: rtl/rps_ctrl.sv
module rps_ctrl #(
   parameter int NUM_RES = 8,
   parameter int TIME_W  = 8,
   parameter int POR_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [POR_W-1:0]           por_len,
   input  logic [NUM_RES-1:0]         req_on,
   input  logic [NUM_RES*NUM_RES-1:0] dep_mask,
   input  logic [NUM_RES*TIME_W-1:0]  up_time,
   input  logic [NUM_RES*TIME_W-1:0]  dn_time,
   output logic [NUM_RES-1:0]         res_en,
   output logic [NUM_RES-1:0]         res_rdy,
   output logic                       clk_avail,
   output logic                       rst_ext_n,
   output logic                       dep_err
);
   import rps_pkg::*;

   localparam int IDX_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1;

   if (NUM_RES < 2 || NUM_RES > 32) begin : g_bad_res
      $error("rps_ctrl: NUM_RES must be within 2..32");
   end
   if (TIME_W < 1 || TIME_W > 16) begin : g_bad_time
      $error("rps_ctrl: TIME_W must be within 1..16");
   end
   if (POR_W < 1 || POR_W > 24) begin : g_bad_por
      $error("rps_ctrl: POR_W must be within 1..24");
   end

   sq_state_t          state_q;
   logic [IDX_W-1:0]   cur_q;
   logic [TIME_W-1:0]  cnt_q;
   logic [NUM_RES-1:0] en_q;
   logic [NUM_RES-1:0] rdy_q;
   logic               por_done;
   logic               up_vld, dn_vld;
   logic [IDX_W-1:0]   up_idx, dn_idx;

   rps_por_stretch #(.POR_W(POR_W)) u_por (
      .clk  (clk),
      .rst_n(rst_n),
      .len  (por_len),
      .done (por_done)
   );

   rps_pick #(.NUM_RES(NUM_RES), .IDX_W(IDX_W)) u_pick (
      .req     (req_on),
      .en      (en_q),
      .rdy     (rdy_q),
      .dep_flat(dep_mask),
      .up_vld  (up_vld),
      .up_idx  (up_idx),
      .dn_vld  (dn_vld),
      .dn_idx  (dn_idx)
   );

   rps_err_mon #(.NUM_RES(NUM_RES)) u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_on),
      .dep_flat(dep_mask),
      .err     (dep_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cur_q   <= '0;
         cnt_q   <= '0;
         en_q    <= '0;
         rdy_q   <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (por_done && up_vld) begin
                  en_q[up_idx] <= 1'b1;
                  cnt_q        <= up_time[up_idx*TIME_W +: TIME_W];
                  cur_q        <= up_idx;
                  state_q      <= SQ_UP;
               end else if (por_done && dn_vld) begin
                  rdy_q[dn_idx] <= 1'b0;
                  cnt_q         <= dn_time[dn_idx*TIME_W +: TIME_W];
                  cur_q         <= dn_idx;
                  state_q       <= SQ_DOWN;
               end
            end
            SQ_UP: begin
               if (cnt_q == '0) begin
                  rdy_q[cur_q] <= 1'b1;
                  state_q      <= SQ_IDLE;
               end else begin
                  cnt_q <= cnt_q - TIME_W'(1);
               end
            end
            SQ_DOWN: begin
               if (cnt_q == '0) begin
                  en_q[cur_q] <= 1'b0;
                  state_q     <= SQ_IDLE;
               end else begin
                  cnt_q <= cnt_q - TIME_W'(1);
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign res_en    = en_q;
   assign res_rdy   = rdy_q;
   assign rst_ext_n = por_done;
   assign clk_avail = por_done & (req_on != '0) & ((req_on & ~rdy_q) == '0);

   AST_ONE_IN_MOTION: assert property (@(posedge clk) disable iff (!rst_n) $countones(en_q ^ rdy_q) <= 1); // R5
   AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) (rdy_q & ~en_q) == '0); // R6
   AST_NO_EN_IN_POR: assert property (@(posedge clk) disable iff (!rst_n) !por_done |-> (en_q == '0)); // R2

   for (genvar i = 0; i < NUM_RES; i++) begin : g_ast
      logic [NUM_RES-1:0] need_a;
      logic [NUM_RES-1:0] user_a;
      assign need_a = dep_mask[i*NUM_RES +: NUM_RES] & ~(NUM_RES'(1) << i);
      for (genvar j = 0; j < NUM_RES; j++) begin : g_u
         if (j == i) begin : g_s
            assign user_a[j] = 1'b0;
         end else begin : g_o
            assign user_a[j] = dep_mask[j*NUM_RES + i];
         end
      end
      AST_UP_AFTER_NEEDS: assert property (@(posedge clk) disable iff (!rst_n) $rose(en_q[i]) |-> ((need_a & ~rdy_q) == '0)); // R3
      AST_DOWN_AFTER_USERS: assert property (@(posedge clk) disable iff (!rst_n) $fell(rdy_q[i]) |-> ((user_a & en_q) == '0)); // R4
   end
endmodule

// File: tb/rps_ctrl_tb.sv
`timescale 1ns/1ps
module rps_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  por_len = 8'd1;
   logic [7:0]  req = 8'h00;
   logic [63:0] dep_flat, up_flat, dn_flat;
   logic [7:0]  res_en, res_rdy;
   logic        clk_avail, rst_ext_n, dep_err;

   logic [7:0] dep_m [8];
   logic [7:0] tu [8];
   logic [7:0] td [8];

   int n_chk = 0;
   int n_fail = 0;
   int now = 0;
   int stp_i [32];
   bit stp_up [32];
   int nst = 0;

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 8; i++) begin
         dep_flat[i*8 +: 8] = dep_m[i];
         up_flat[i*8 +: 8]  = tu[i];
         dn_flat[i*8 +: 8]  = td[i];
      end
   end

   rps_ctrl u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .por_len  (por_len),
      .req_on   (req),
      .dep_mask (dep_flat),
      .up_time  (up_flat),
      .dn_time  (dn_flat),
      .res_en   (res_en),
      .res_rdy  (res_rdy),
      .clk_avail(clk_avail),
      .rst_ext_n(rst_ext_n),
      .dep_err  (dep_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic go_to(input int k);
      while (now < k) begin
         @(negedge clk);
         now++;
      end
   endtask

   task automatic do_reset(input int len);
      rst_n = 1'b0;
      por_len = 8'(len);
      repeat (3) @(negedge clk);
      chk("R12 en", res_en, 0);
      chk("R12 rdy", res_rdy, 0);
      chk("R12 ext", rst_ext_n, 0);
      chk("R12 avail", clk_avail, 0);
      chk("R12 err", dep_err, 0);
      rst_n = 1'b1;
      now = 0;
   endtask

   task automatic set_cfg(input int kind);
      for (int i = 0; i < 8; i++) begin
         case (kind)
            0: begin dep_m[i] = 8'h00; tu[i] = 8'd1; td[i] = 8'd1; end
            1: begin dep_m[i] = (i == 0) ? 8'h00 : 8'(1 << (i-1)); tu[i] = 8'(i+1); td[i] = 8'(8-i); end
            default: begin dep_m[i] = (i == 0) ? 8'h20 : 8'h00; tu[i] = 8'((3*i) % 5); td[i] = 8'(i % 3); end
         endcase
      end
   endtask

   // Transition order from the rules of R3, R4 and R5
   task automatic plan(input logic [7:0] from, input logic [7:0] to);
      logic [7:0] on;
      int pick;
      bit up;
      bit used;
      on = from;
      nst = 0;
      up = 1'b0;
      for (int k = 0; k < 32; k++) begin
         pick = -1;
         for (int i = 7; i >= 0; i--)
            if (to[i] && !on[i] && ((dep_m[i] & ~(8'(1) << i) & ~on) == 8'h00)) begin
               pick = i; up = 1'b1;
            end
         if (pick < 0)
            for (int i = 0; i < 8; i++) begin
               used = 1'b0;
               for (int j = 0; j < 8; j++)
                  if (j != i && on[j] && dep_m[j][i]) used = 1'b1;
               if (!to[i] && on[i] && !used) begin
                  pick = i; up = 1'b0;
               end
            end
         if (pick < 0) break;
         stp_i[nst] = pick;
         stp_up[nst] = up;
         nst++;
         on[pick] = up;
      end
   endtask

   task automatic run_seq(input logic [7:0] from, input logic [7:0] to);
      int s;
      int i;
      int t;
      plan(from, to);
      req = to;
      now = 0;
      s = 1;
      for (int k = 0; k < nst; k++) begin
         i = stp_i[k];
         if (stp_up[k]) begin
            t = tu[i];
            go_to(s);
            chk("R5 R6 enable rises on selection", res_en[i], 1);
            chk("R6 not ready at selection", res_rdy[i], 0);
            go_to(s + t);
            chk("R6 ready not early", res_rdy[i], 0);
            if (k == nst - 1) chk("R9 avail low before last ready", clk_avail, 0);
            go_to(s + t + 1);
            chk("R6 ready after settle", res_rdy[i], 1);
         end else begin
            t = td[i];
            go_to(s);
            chk("R5 R7 ready falls on selection", res_rdy[i], 0);
            chk("R7 enable held at selection", res_en[i], 1);
            go_to(s + t);
            chk("R7 enable not dropped early", res_en[i], 1);
            go_to(s + t + 1);
            chk("R7 enable off after settle", res_en[i], 0);
         end
         s = s + t + 2;
      end
      go_to(s);
      chk("R11 final ready set", res_rdy, to);
      chk("R11 final enable set", res_en, to);
      chk("R9 clk_avail at end", clk_avail, (to != 8'h00) ? 1 : 0);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      finish_run();
   end

   initial begin
      set_cfg(0);

      // R1 R2: extended reset sweep
      for (int l = 0; l < 12; l += 4) begin
         req = 8'h01;
         tu[0] = 8'd2;
         do_reset(l);
         chk("R1 ext low at release", rst_ext_n, 0);
         go_to(l);
         chk("R1 ext low before L+1", rst_ext_n, 0);
         go_to(l + 1);
         chk("R1 ext high at L+1", rst_ext_n, 1);
         chk("R2 no enable yet", res_en, 0);
         go_to(l + 2);
         chk("R2 first selection", res_en, 1);
         go_to(l + 6);
         chk("R1 ext stays high", rst_ext_n, 1);
      end

      // chained needs: all up then all down
      set_cfg(1);
      req = 8'h00;
      do_reset(1);
      go_to(2);
      run_seq(8'h00, 8'hFF);
      run_seq(8'hFF, 8'h00);
      chk("R10 no error on valid pattern", dep_err, 0);

      // reverse need (r0 needs r5) and mixed settle counts
      set_cfg(2);
      do_reset(1);
      go_to(2);
      run_seq(8'h00, 8'hFF);
      run_seq(8'hFF, 8'h00);
      run_seq(8'h00, 8'h21);

      // individual switch-off
      set_cfg(0);
      do_reset(1);
      go_to(2);
      run_seq(8'h00, 8'hFF);
      run_seq(8'hFF, 8'hF7);
      run_seq(8'hF7, 8'hFF);

      // R8: request dropped mid-settle
      set_cfg(0);
      tu[0] = 8'd10;
      td[0] = 8'd4;
      do_reset(1);
      go_to(2);
      req = 8'h01;
      now = 0;
      go_to(3);
      req = 8'h00;
      go_to(11);
      chk("R8 ready still settling", res_rdy[0], 0);
      go_to(12);
      chk("R8 up completes despite change", res_rdy[0], 1);
      chk("R8 enable held", res_en[0], 1);
      go_to(13);
      chk("R8 down starts after settle", res_rdy[0], 0);
      go_to(17);
      chk("R8 enable kept during down settle", res_en[0], 1);
      go_to(18);
      chk("R8 enable off", res_en[0], 0);

      // R10 R3: unmet need
      set_cfg(0);
      dep_m[1] = 8'h01;
      do_reset(1);
      go_to(2);
      req = 8'h02;
      now = 0;
      chk("R10 err low before edge", dep_err, 0);
      go_to(1);
      chk("R10 err set", dep_err, 1);
      go_to(20);
      chk("R3 blocked resource never enabled", res_en, 0);
      chk("R9 avail low while unmet", clk_avail, 0);
      req = 8'h00;
      go_to(25);
      chk("R10 err sticky", dep_err, 1);
      do_reset(1);
      chk("R10 err cleared by reset", dep_err, 0);

      finish_run();
   end
endmodule